// File: doc/BRIEF.md
# Packed Multiply, Sign and Absolute Unit

This block is a SIMD execution unit with a single registered stage. It takes two packed operands, a destination operand and a source operand, and an 8-bit secondary operation code. It returns one packed result. The datapath supports four operations.

- A byte multiply-add that mixes unsigned and signed bytes and saturates each sum to a word.
- A rounded word multiply that keeps the high half of the product.
- A conditional negate driven by the sign of each source element.
- An absolute value at byte, word or doubleword size.

The register width is a parameter and may be 64 or 128 bits. Decoding and operand fetch are done upstream. The upstream stage presents one operation per `in_valid` strobe, and the unit answers one clock later.

Element i of a given width EW occupies bits [i*EW +: EW], so element 0 sits in the least significant bits. The unit flags an operation code it does not implement. In that case the result is zero.

Top module: `pmsa_unit`

## Requirements
- R1: For every cycle with `in_valid` high, `out_valid` is high in the next cycle, and `result` and `op_err` are updated there. When `in_valid` is low, `out_valid` is low one cycle later and `result` keeps its value.
- R2: Opcode 0x04 computes word k as the sum of signed source byte 2k times unsigned destination byte 2k and signed source byte 2k+1 times unsigned destination byte 2k+1. The sum is clamped to the range -32768..32767. For example, bytes 0xff (destination) and 0x7f (source) give 0x7fff.
- R3: Opcode 0x0b forms the signed 16x16 product of each destination word and source word. It adds 0x4000, shifts right arithmetically by 15 and keeps the low 16 bits. The pair 0x8000 x 0x8000 gives 0x8000.
- R4: Opcodes 0x08, 0x09 and 0x0a act on bytes, words and doublewords respectively. Each result element depends on the source element: negative gives the two's-complement negation of the destination element, zero gives zero, and positive gives the destination element unchanged. Negating the most negative value wraps to itself.
- R5: Opcodes 0x1c, 0x1d and 0x1e give the absolute value of each source byte, word or doubleword respectively. The most negative value is returned as itself, and the destination operand has no effect on the result.
- R6: Any other opcode sets `op_err` together with `out_valid` and produces an all-zero result. `op_err` is low for the supported opcodes.
- R7: While `rst` is high at a clock edge, the next cycle shows `out_valid` low, `op_err` low and `result` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe, one operation per cycle |
| op_code | input | 8 | Secondary operation code |
| dst_opnd | input | REG_W | Destination operand |
| src_opnd | input | REG_W | Source operand |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | REG_W | Packed result |
| op_err | output | 1 | Unsupported opcode flag |

## Verification
The assertions assume that the operands and opcode are steady around the sampling edge whenever `in_valid` is high. They also assume that reset is held for at least one edge before the first strobe. The stimulus meets both assumptions by changing inputs only on the falling clock edge and by pulsing reset for several cycles at start. Each operation is sent as a one-cycle strobe, either separated by idle cycles or issued back to back, so both the valid chain and the hold behaviour are exercised. Saturation, wrap and zero-source corners are sent as directed vectors alongside randomized operands.

// File: rtl/pmsa_pkg.sv
package pmsa_pkg;
  localparam logic [7:0] OPC_MADD  = 8'h04;
  localparam logic [7:0] OPC_SGNB  = 8'h08;
  localparam logic [7:0] OPC_SGNW  = 8'h09;
  localparam logic [7:0] OPC_SGND  = 8'h0a;
  localparam logic [7:0] OPC_MULHR = 8'h0b;
  localparam logic [7:0] OPC_ABSB  = 8'h1c;
  localparam logic [7:0] OPC_ABSW  = 8'h1d;
  localparam logic [7:0] OPC_ABSD  = 8'h1e;
endpackage

// File: rtl/pmsa_madd.sv
module pmsa_madd #(
  parameter int REG_W = 128
) (
  input  logic [REG_W-1:0] dst_v,
  input  logic [REG_W-1:0] src_v,
  output logic [REG_W-1:0] res_v
);
  localparam int NWORD = REG_W / 16;

  for (genvar k = 0; k < NWORD; k++) begin : g_word
    logic signed [16:0] prod_lo, prod_hi;
    logic signed [17:0] acc;
    logic [15:0] sat;
    always_comb begin
      prod_lo = $signed(src_v[16*k +: 8]) * $signed({1'b0, dst_v[16*k +: 8]});
      prod_hi = $signed(src_v[16*k+8 +: 8]) * $signed({1'b0, dst_v[16*k+8 +: 8]});
      acc = {prod_lo[16], prod_lo} + {prod_hi[16], prod_hi};
      if (acc > 18'sd32767)       sat = 16'h7fff;
      else if (acc < -18'sd32768) sat = 16'h8000;
      else                        sat = acc[15:0];
    end
    assign res_v[16*k +: 16] = sat;
  end
endmodule

// File: rtl/pmsa_mulhr.sv
module pmsa_mulhr #(
  parameter int REG_W = 128
) (
  input  logic [REG_W-1:0] dst_v,
  input  logic [REG_W-1:0] src_v,
  output logic [REG_W-1:0] res_v
);
  localparam int NWORD = REG_W / 16;
  localparam logic signed [31:0] RND = 32'sh4000;

  for (genvar k = 0; k < NWORD; k++) begin : g_word
    logic signed [31:0] prod, rnd;
    always_comb begin
      prod = $signed(dst_v[16*k +: 16]) * $signed(src_v[16*k +: 16]);
      rnd  = prod + RND;
    end
    assign res_v[16*k +: 16] = 16'(rnd >>> 15);
  end
endmodule

// File: rtl/pmsa_signabs.sv
module pmsa_signabs #(
  parameter int REG_W = 128,
  parameter int EW    = 8
) (
  input  logic [REG_W-1:0] dst_v,
  input  logic [REG_W-1:0] src_v,
  output logic [REG_W-1:0] sign_v,
  output logic [REG_W-1:0] abs_v
);
  localparam int NEL = REG_W / EW;

  for (genvar i = 0; i < NEL; i++) begin : g_el
    logic [EW-1:0] s_el, d_el;
    assign s_el = src_v[EW*i +: EW];
    assign d_el = dst_v[EW*i +: EW];
    always_comb begin
      if (s_el[EW-1])       sign_v[EW*i +: EW] = -d_el;
      else if (s_el == '0)  sign_v[EW*i +: EW] = '0;
      else                  sign_v[EW*i +: EW] = d_el;
      abs_v[EW*i +: EW] = s_el[EW-1] ? -s_el : s_el;
    end
  end
endmodule

// File: rtl/pmsa_unit.sv
module pmsa_unit
  import pmsa_pkg::*;
#(
  parameter int REG_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       op_code,
  input  logic [REG_W-1:0] dst_opnd,
  input  logic [REG_W-1:0] src_opnd,
  output logic             out_valid,
  output logic [REG_W-1:0] result,
  output logic             op_err
);
  localparam int NSZ = 3;

  logic [REG_W-1:0] madd_r, mulhr_r;
  logic [REG_W-1:0] sign_r [NSZ];
  logic [REG_W-1:0] abs_r  [NSZ];
  logic [REG_W-1:0] sel_r;
  logic             sel_err;

  pmsa_madd #(.REG_W(REG_W)) u_madd (
    .dst_v(dst_opnd), .src_v(src_opnd), .res_v(madd_r)
  );

  pmsa_mulhr #(.REG_W(REG_W)) u_mulhr (
    .dst_v(dst_opnd), .src_v(src_opnd), .res_v(mulhr_r)
  );

  for (genvar z = 0; z < NSZ; z++) begin : g_sz
    pmsa_signabs #(.REG_W(REG_W), .EW(8 << z)) u_sa (
      .dst_v(dst_opnd), .src_v(src_opnd),
      .sign_v(sign_r[z]), .abs_v(abs_r[z])
    );
  end

  always_comb begin
    sel_err = 1'b0;
    case (op_code)
      OPC_MADD:  sel_r = madd_r;
      OPC_MULHR: sel_r = mulhr_r;
      OPC_SGNB:  sel_r = sign_r[0];
      OPC_SGNW:  sel_r = sign_r[1];
      OPC_SGND:  sel_r = sign_r[2];
      OPC_ABSB:  sel_r = abs_r[0];
      OPC_ABSW:  sel_r = abs_r[1];
      OPC_ABSD:  sel_r = abs_r[2];
      default: begin
        sel_r   = '0;
        sel_err = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      op_err    <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      op_err    <= in_valid & sel_err;
      if (in_valid) result <= sel_r;
    end
  end
endmodule

// File: rtl/pmsa_unit_chk.sv
module pmsa_unit_chk #(
  parameter int REG_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [7:0]       op_code,
  input logic [REG_W-1:0] dst_opnd,
  input logic [REG_W-1:0] src_opnd,
  input logic             out_valid,
  input logic [REG_W-1:0] result,
  input logic             op_err
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    op_err |-> (out_valid && result == '0));

  // R3
  mulhr_corner_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 8'h0b && dst_opnd[15:0] == 16'h8000 &&
     src_opnd[15:0] == 16'h8000) |=> result[15:0] == 16'h8000);

  // R5
  abs_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == 8'h1c) |=> result[7] == ($past(src_opnd[7:0]) == 8'h80));

  // R7
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !op_err && result == '0));
endmodule

bind pmsa_unit pmsa_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
  .dst_opnd(dst_opnd), .src_opnd(src_opnd), .out_valid(out_valid),
  .result(result), .op_err(op_err)
);

// File: tb/test_pmsa_unit.sv
`timescale 1ns/1ps
module test_pmsa_unit;
  localparam int W = 128;

  logic         clk = 0;
  logic         rst = 1;
  logic         in_valid = 0;
  logic [7:0]   op_code = 0;
  logic [W-1:0] dst_opnd = '0;
  logic [W-1:0] src_opnd = '0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         op_err;

  int n_cmp = 0;
  int n_bad = 0;
  logic [W:0] exp_q [$];
  string      tag_q [$];
  logic [W-1:0] last_exp = '0;

  always #2.5 clk = ~clk;

  pmsa_unit #(.REG_W(W)) i_pmsa_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .dst_opnd(dst_opnd), .src_opnd(src_opnd), .out_valid(out_valid),
    .result(result), .op_err(op_err)
  );

  function automatic longint elem(logic [W-1:0] v, int i, int ew);
    logic [W-1:0] t;
    longint one, x;
    one = 1;
    t = v >> (i * ew);
    x = longint'(t[31:0]) & ((one << ew) - 1);
    if (x >= (one << (ew - 1))) x = x - (one << ew);
    return x;
  endfunction

  function automatic logic [W-1:0] put(logic [W-1:0] acc, longint x, int i, int ew);
    longint one;
    one = 1;
    return acc | (W'(x & ((one << ew) - 1)) << (i * ew));
  endfunction

  function automatic logic [W:0] model(logic [7:0] op, logic [W-1:0] d, logic [W-1:0] s);
    logic [W-1:0] r;
    int ew;
    r = '0;
    case (op)
      8'h04: for (int k = 0; k < W/16; k++) begin
        longint sm;
        sm = elem(s, 2*k, 8) * (elem(d, 2*k, 8) & 255) +
             elem(s, 2*k+1, 8) * (elem(d, 2*k+1, 8) & 255);
        if (sm > 32767) sm = 32767;
        if (sm < -32768) sm = -32768;
        r = put(r, sm, k, 16);
      end
      8'h0b: for (int k = 0; k < W/16; k++) begin
        longint p;
        p = (elem(d, k, 16) * elem(s, k, 16) + 16384) >>> 15;
        r = put(r, p, k, 16);
      end
      8'h08, 8'h09, 8'h0a: begin
        ew = 8 << (op - 8'h08);
        for (int i = 0; i < W/ew; i++) begin
          longint sv, dv;
          sv = elem(s, i, ew);
          dv = elem(d, i, ew);
          r = put(r, (sv < 0) ? -dv : (sv == 0) ? 0 : dv, i, ew);
        end
      end
      8'h1c, 8'h1d, 8'h1e: begin
        ew = 8 << (op - 8'h1c);
        for (int i = 0; i < W/ew; i++) begin
          longint sv;
          sv = elem(s, i, ew);
          r = put(r, (sv < 0) ? -sv : sv, i, ew);
        end
      end
      default: return {1'b1, {W{1'b0}}};
    endcase
    return {1'b0, r};
  endfunction

  task automatic drive(input logic [7:0] op, input logic [W-1:0] d,
                       input logic [W-1:0] s, input string tag);
    logic [W:0] e;
    e = model(op, d, s);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_exp = e[W-1:0];
    @(negedge clk);
    in_valid = 1; op_code = op; dst_opnd = d; src_opnd = s;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [W:0] act,
                       input logic [W:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per valid result.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R1 unexpected out_valid", {op_err, result}, '0);
      end else begin
        logic [W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({op_err, result} === e, t, {op_err, result}, e);
      end
    end
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R7 reset state
    check(out_valid === 0 && op_err === 0 && result === '0, "R7 reset",
          {op_err, result}, '0);

    // R2 saturation high and low, then mixed data
    drive(8'h04, {16{8'hff}}, {16{8'h7f}}, "R2 sat high");
    drive(8'h04, {16{8'hff}}, {16{8'h80}}, "R2 sat low");
    drive(8'h04, 128'h0102_0304_0506_0708_ff80_7f01_1020_3040,
                 128'hff01_80ff_0203_fe7f_0102_8081_f0e0_0f0e, "R2 mixed");
    // R3 corner and ordinary
    drive(8'h0b, {8{16'h8000}}, {8{16'h8000}}, "R3 most negative pair");
    drive(8'h0b, 128'h7fff_4000_c000_0001_1234_8000_ffff_0100,
                 128'h7fff_4000_4000_7fff_edcb_7fff_ffff_0080, "R3 mixed");
    idle(2);
    // R4 sign, all three widths with zero and negative sources
    drive(8'h08, 128'h80_01_7f_05_00_ff_10_20_30_40_50_60_70_80_90_a0,
                 128'hff_00_01_80_7f_00_ff_01_00_00_80_7f_01_ff_00_05, "R4 bytes");
    drive(8'h09, 128'h8000_1234_0001_ffff_7fff_0000_5555_aaaa,
                 128'hffff_0000_8000_0001_0000_ffff_7fff_8001, "R4 words");
    drive(8'h0a, 128'h8000_0000_1234_5678_0000_0001_dead_beef,
                 128'hffff_ffff_0000_0000_7fff_ffff_8000_0000, "R4 dwords");
    // R5 abs, destination must not matter
    a = 128'h80_7f_ff_00_01_81_fe_02_80_00_7f_c0_40_33_cc_ee;
    drive(8'h1c, '0, a, "R5 bytes");
    drive(8'h1c, '1, a, "R5 bytes dst ignored");
    drive(8'h1d, 128'h1, 128'h8000_7fff_ffff_0000_0001_8001_c000_1234, "R5 words");
    drive(8'h1e, 128'h5, 128'h8000_0000_7fff_ffff_ffff_ffff_0000_0000, "R5 dwords");
    // R6 unsupported codes
    drive(8'h00, '1, '1, "R6 op 00");
    drive(8'h0c, '1, '1, "R6 op 0c");
    drive(8'hff, '1, '1, "R6 op ff");
    // R1 hold after idle
    drive(8'h1d, '0, 128'hffff_0002_0003_0004_0005_0006_0007_8000, "R1 last op");
    idle(4);
    check(out_valid === 0 && result === last_exp, "R1 hold",
          {op_err, result}, {1'b0, last_exp});

    // Random sweep over all supported codes
    for (int n = 0; n < 40; n++) begin
      logic [7:0] ops [8];
      ops = '{8'h04, 8'h0b, 8'h08, 8'h09, 8'h0a, 8'h1c, 8'h1d, 8'h1e};
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      drive(ops[n % 8], a, b, "R2-R5 random");
    end
    idle(4);
    check(exp_q.size() == 0, "R1 all results returned", W'(exp_q.size()), '0);

    // R7 reset mid-run clears outputs
    drive(8'h1c, '0, '1, "R7 pre-reset");
    idle(2);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(out_valid === 0 && op_err === 0 && result === '0, "R7 reset again",
          {op_err, result}, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule